// File: doc/BRIEF.md
# Eight-Channel Register Bank with Maskable Interrupts

This block is the register file behind a host port for a device with eight identical line channels. The host uses a plain synchronous register bus: a 16-bit address, 16-bit write data with two byte-lane enables, and one-cycle read and write strobes. Read data comes back from a register one cycle after the read strobe and holds until the next read.

The upper address byte selects the bank. Value 00h reaches the global registers and channel 0, and values 01h to 07h reach channels 1 to 7. Inside a bank the lower byte is the register offset. The global registers sit at low offsets: configuration at 00h, event flags at 02h and event enables-off (mask) at 04h. The channel registers sit at 10h and above: configuration at 10h, live status at 12h, event flags at 14h and mask at 16h. Because the two sets of offsets differ, the global registers and channel 0 share upper byte 00h without overlapping.

Each channel has a read/write configuration word and a status word that the channel logic drives continuously. It also has an event-flag word that latches single-cycle event pulses and is cleared by reading it, with a mask word beside it. The global bank has its own configuration word, event flags and mask. A single active-low interrupt line is asserted while any flag is set and not masked. Global configuration bit 0 turns on per-channel rate selection: when it is 1, each channel's configuration bit 0 picks that channel's rate on its own. When it is 0, global configuration bit 1 sets the rate for every channel.

Top module: `chan_regbank`

## Requirements
- R1: A write updates only the byte lanes whose enable is set: lane 0 is bits 7:0 and lane 1 is bits 15:8. A word write (both enables set) updates both bytes in one cycle. Each channel's configuration word appears on its slice of `ch_cfg_o`.
- R2: A read of a channel status register (offset 12h) returns that channel's `ch_stat_i` slice as sampled at the read strobe.
- R3: An event pulse sets its flag bit. The bit stays set until a read of that flag register (global 02h, channel 14h). The read returns the value held before the clear, and clears only the byte lanes enabled on the read.
- R4: When an event arrives in the same cycle as a read that clears its bit, the bit stays set.
- R5: All mask registers (global 04h, channel 16h) reset to FFFFh and are read/write.
- R6: `irq_n` is 0 exactly when some flag bit is 1 and its mask bit is 0, in any channel or in the global bank. A mask bit of 1 blocks its flag.
- R7: An upper address byte n in the range 0 to 7 selects channel n's registers. An access to one channel leaves the other channels unchanged.
- R8: The global registers decode at upper byte 00h, offsets 00h, 02h and 04h, and do not alias channel 0's offsets.
- R9: A read of an undecoded address returns 0000h and clears nothing. Writes to status or flag registers, or to undecoded addresses, have no effect.
- R10: `ch_t1_o[n]` equals channel n configuration bit 0 when global configuration bit 0 is 1. Otherwise every bit equals global configuration bit 1. A value of 0 means E1 rate and 1 means T1 rate.
- R11: After reset the global configuration is 0001h (per-channel mode, E1 rate), channel configurations are 0000h, flags are clear and `irq_n` is 1.
- R12: `bus_rdata` loads in the cycle after a read strobe and keeps its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register address: upper byte selects the bank, lower byte the offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_be | input | 2 | Byte-lane enables for writes and read-clears |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| glb_evt_i | input | 16 | Global event pulses |
| ch_evt_i | input | 128 | Event pulses, 16 bits per channel |
| ch_stat_i | input | 128 | Live status, 16 bits per channel |
| ch_cfg_o | output | 128 | Configuration words, 16 bits per channel |
| ch_t1_o | output | 8 | Effective rate per channel (1 = T1) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench targets an event that lands in the same cycle as the read that clears it. A design that lets the clear win drops the event silently, and the line goes high with a bit still owed. It also issues byte-lane reads of the flag register, which expose a design that clears the whole word. It reads odd offsets, out-of-range channels and offsets between the two sets, where a sloppy decoder would return an alias or clear a flag. Finally it toggles the global rate mode, which catches a design that ignores the fixed mode or applies it to only some channels.

// File: rtl/crb_pkg.sv
// crb_pkg: register offsets, reset values and offset decode shared by the
// register bank. Assumes word registers at even offsets; odd offsets never hit.
package crb_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTL,
        RK_STAT,
        RK_ISR,
        RK_MASK
    } reg_kind_e;

    localparam logic [7:0] OFS_G_CTL  = 8'h00;
    localparam logic [7:0] OFS_G_ISR  = 8'h02;
    localparam logic [7:0] OFS_G_MASK = 8'h04;
    localparam logic [7:0] OFS_C_CTL  = 8'h10;
    localparam logic [7:0] OFS_C_STAT = 8'h12;
    localparam logic [7:0] OFS_C_ISR  = 8'h14;
    localparam logic [7:0] OFS_C_MASK = 8'h16;

    localparam int G_FLEX_BIT = 0;
    localparam int G_T1_BIT   = 1;
    localparam int C_T1_BIT   = 0;

    // Offset decode within the global bank.
    function automatic reg_kind_e glob_kind(input logic [7:0] ofs);
        case (ofs)
            OFS_G_CTL:  return RK_CTL;
            OFS_G_ISR:  return RK_ISR;
            OFS_G_MASK: return RK_MASK;
            default:    return RK_NONE;
        endcase
    endfunction

    // Offset decode within a channel bank.
    function automatic reg_kind_e chan_kind(input logic [7:0] ofs);
        case (ofs)
            OFS_C_CTL:  return RK_CTL;
            OFS_C_STAT: return RK_STAT;
            OFS_C_ISR:  return RK_ISR;
            OFS_C_MASK: return RK_MASK;
            default:    return RK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/crb_isr_reg.sv
// crb_isr_reg: one event-flag word with its mask word.
// Flags set on event pulses and clear on a read of the enabled lanes; an event
// in the clearing cycle wins. Mask resets to all ones (everything blocked).
module crb_isr_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] lane_bits_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] isr_o,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);

    logic [W-1:0] isr_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] clr_bits;

    // Lanes cleared by this cycle's read.
    assign clr_bits = clr_i ? lane_bits_i : '0;

    // Flag storage: clear first, then OR in events so a new event survives.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~clr_bits) | evt_i;
    end

    // Mask storage: lane-wise write.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (mask_we_i) mask_q <= (mask_q & ~lane_bits_i) | (wdata_i & lane_bits_i);
    end

    assign isr_o  = isr_q;
    assign mask_o = mask_q;
    assign pend_o = |(isr_q & ~mask_q);

endmodule

// File: rtl/crb_chan_bank.sv
// crb_chan_bank: registers of one line channel (configuration, live status,
// event flags, mask). Assumes sel_i is already qualified by the upper address
// byte; returns zero read data when nothing decodes.
module crb_chan_bank
    import crb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_i,
    input  logic         wr_i,
    input  logic         rd_i,
    input  logic [7:0]   ofs_i,
    input  logic [W-1:0] lane_bits_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] stat_i,
    output logic [W-1:0] rdata_o,
    output logic [W-1:0] cfg_o,
    output logic         pend_o
);

    reg_kind_e    kind;
    logic [W-1:0] cfg_q;
    logic [W-1:0] isr_w;
    logic [W-1:0] mask_w;

    // Register selected by this access.
    assign kind = sel_i ? chan_kind(ofs_i) : RK_NONE;

    // Configuration word, lane-wise write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cfg_q <= '0;
        else if (wr_i && kind == RK_CTL) cfg_q <= (cfg_q & ~lane_bits_i) | (wdata_i & lane_bits_i);
    end

    crb_isr_reg #(.W(W)) isr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .clr_i       (rd_i && kind == RK_ISR),
        .mask_we_i   (wr_i && kind == RK_MASK),
        .lane_bits_i (lane_bits_i),
        .wdata_i     (wdata_i),
        .isr_o       (isr_w),
        .mask_o      (mask_w),
        .pend_o      (pend_o)
    );

    // Read data selection.
    always_comb begin
        case (kind)
            RK_CTL:  rdata_o = cfg_q;
            RK_STAT: rdata_o = stat_i;
            RK_ISR:  rdata_o = isr_w;
            RK_MASK: rdata_o = mask_w;
            default: rdata_o = '0;
        endcase
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/crb_glob_bank.sv
// crb_glob_bank: device-wide registers (configuration with rate mode bits,
// event flags, mask). Assumes sel_i means upper address byte 00h.
module crb_glob_bank
    import crb_pkg::*;
#(
    parameter int           W       = 16,
    parameter logic [W-1:0] CTL_RST = W'(1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_i,
    input  logic         wr_i,
    input  logic         rd_i,
    input  logic [7:0]   ofs_i,
    input  logic [W-1:0] lane_bits_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] evt_i,
    output logic [W-1:0] rdata_o,
    output logic         flex_o,
    output logic         t1_o,
    output logic [W-1:0] isr_o,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);

    reg_kind_e    kind;
    logic [W-1:0] ctl_q;

    // Register selected by this access.
    assign kind = sel_i ? glob_kind(ofs_i) : RK_NONE;

    // Global configuration word, lane-wise write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ctl_q <= CTL_RST;
        else if (wr_i && kind == RK_CTL) ctl_q <= (ctl_q & ~lane_bits_i) | (wdata_i & lane_bits_i);
    end

    crb_isr_reg #(.W(W)) isr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .clr_i       (rd_i && kind == RK_ISR),
        .mask_we_i   (wr_i && kind == RK_MASK),
        .lane_bits_i (lane_bits_i),
        .wdata_i     (wdata_i),
        .isr_o       (isr_o),
        .mask_o      (mask_o),
        .pend_o      (pend_o)
    );

    // Read data selection.
    always_comb begin
        case (kind)
            RK_CTL:  rdata_o = ctl_q;
            RK_ISR:  rdata_o = isr_o;
            RK_MASK: rdata_o = mask_o;
            default: rdata_o = '0;
        endcase
    end

    assign flex_o = ctl_q[G_FLEX_BIT];
    assign t1_o   = ctl_q[G_T1_BIT];

endmodule

// File: rtl/chan_regbank.sv
// chan_regbank: top of the register bank. Decodes the upper address byte into
// the global bank and NUM_CH channel banks, registers read data, derives each
// channel's effective rate and drives the shared active-low interrupt.
// Assumes single-cycle strobes and DATA_W a multiple of 8.
module chan_regbank
    import crb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [DATA_W/8-1:0]      bus_be,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [DATA_W-1:0]        glb_evt_i,
    input  logic [NUM_CH*DATA_W-1:0] ch_evt_i,
    input  logic [NUM_CH*DATA_W-1:0] ch_stat_i,
    output logic [NUM_CH*DATA_W-1:0] ch_cfg_o,
    output logic [NUM_CH-1:0]        ch_t1_o,
    output logic                     irq_n
);

    localparam int BE_W = DATA_W / 8;
    localparam int HI_W = ADDR_W - 8;

    logic [HI_W-1:0]   hi_byte;
    logic [7:0]        ofs;
    logic [DATA_W-1:0] lane_bits;
    logic [DATA_W-1:0] glob_rdata;
    logic [DATA_W-1:0] glob_isr_w;
    logic [DATA_W-1:0] glob_mask_w;
    logic              glob_flex_w;
    logic              glob_t1_w;
    logic              glob_pend;
    logic [DATA_W-1:0] ch_rdata [NUM_CH];
    logic [NUM_CH-1:0] ch_pend;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    assign hi_byte = bus_addr[ADDR_W-1:8];
    assign ofs     = bus_addr[7:0];

    // Expand byte enables into per-bit lane bits.
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign lane_bits[b*8 +: 8] = {8{bus_be[b]}};
    end

    crb_glob_bank #(.W(DATA_W), .CTL_RST(DATA_W'(1) << G_FLEX_BIT)) glob_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (hi_byte == '0),
        .wr_i        (bus_wr),
        .rd_i        (bus_rd),
        .ofs_i       (ofs),
        .lane_bits_i (lane_bits),
        .wdata_i     (bus_wdata),
        .evt_i       (glb_evt_i),
        .rdata_o     (glob_rdata),
        .flex_o      (glob_flex_w),
        .t1_o        (glob_t1_w),
        .isr_o       (glob_isr_w),
        .mask_o      (glob_mask_w),
        .pend_o      (glob_pend)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [DATA_W-1:0] cfg_w;

        crb_chan_bank #(.W(DATA_W)) bank_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel_i       (hi_byte == HI_W'(c)),
            .wr_i        (bus_wr),
            .rd_i        (bus_rd),
            .ofs_i       (ofs),
            .lane_bits_i (lane_bits),
            .wdata_i     (bus_wdata),
            .evt_i       (ch_evt_i[c*DATA_W +: DATA_W]),
            .stat_i      (ch_stat_i[c*DATA_W +: DATA_W]),
            .rdata_o     (ch_rdata[c]),
            .cfg_o       (cfg_w),
            .pend_o      (ch_pend[c])
        );

        assign ch_cfg_o[c*DATA_W +: DATA_W] = cfg_w;
        // Per-channel rate in flexible mode, shared rate otherwise.
        assign ch_t1_o[c] = glob_flex_w ? cfg_w[C_T1_BIT] : glob_t1_w;
    end

    // Merge bank read data; non-selected banks return zero.
    always_comb begin
        rd_mux = glob_rdata;
        for (int c = 0; c < NUM_CH; c++) rd_mux = rd_mux | ch_rdata[c];
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign irq_n     = ~(glob_pend | (|ch_pend));

endmodule

// File: rtl/crb_checker.sv
// crb_checker: protocol and behaviour properties for chan_regbank, bound in.
module crb_checker #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_n,
    input logic [DATA_W-1:0] glb_evt,
    input logic [DATA_W-1:0] glob_isr,
    input logic [DATA_W-1:0] glob_mask,
    input logic              flex,
    input logic [NUM_CH-1:0] ch_t1
);

    // Independent address legality check.
    function automatic logic undecoded(input logic [ADDR_W-1:0] a);
        logic [7:0] lo;
        logic       chan_ok;
        logic       glob_ok;
        lo      = a[7:0];
        chan_ok = (int'(a[ADDR_W-1:8]) < NUM_CH) &&
                  (lo == 8'h10 || lo == 8'h12 || lo == 8'h14 || lo == 8'h16);
        glob_ok = (a[ADDR_W-1:8] == '0) && (lo == 8'h00 || lo == 8'h02 || lo == 8'h04);
        return !(chan_ok || glob_ok);
    endfunction

    AST_IRQ_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> irq_n); // R11

    AST_UNDECODED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && undecoded(bus_addr)) |=> (bus_rdata == '0)); // R9

    AST_UNMASKED_EVENT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && |(glb_evt & ~glob_mask)) |=> !irq_n); // R4

    AST_FLAGS_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_rd)) |-> ((glob_isr & $past(glob_isr)) == $past(glob_isr))); // R3

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_rd)) |-> $stable(bus_rdata)); // R12

    AST_FIXED_RATE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        !flex |-> (ch_t1 == '0 || ch_t1 == '1)); // R10

endmodule

bind chan_regbank crb_checker #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n),
    .glb_evt   (glb_evt_i),
    .glob_isr  (glob_isr_w),
    .glob_mask (glob_mask_w),
    .flex      (glob_flex_w),
    .ch_t1     (ch_t1_o)
);

// File: tb/chan_regbank_tb_top.sv
// Bench: behavioural reference model updated on every rising edge, compared
// with the design on every falling edge, plus directed checks with literal
// expected values.
module chan_regbank_tb_top;

    localparam int NCH = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [15:0]     bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [1:0]      bus_be = '0;
    logic [15:0]     bus_wdata = '0;
    logic [15:0]     bus_rdata;
    logic [15:0]     glb_evt_i = '0;
    logic [NCH*16-1:0] ch_evt_i = '0;
    logic [NCH*16-1:0] ch_stat_i = '0;
    logic [NCH*16-1:0] ch_cfg_o;
    logic [NCH-1:0]  ch_t1_o;
    logic            irq_n;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit started = 0;

    always #2.5 clk = ~clk; // 200 MHz

    chan_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .glb_evt_i(glb_evt_i), .ch_evt_i(ch_evt_i),
        .ch_stat_i(ch_stat_i), .ch_cfg_o(ch_cfg_o), .ch_t1_o(ch_t1_o),
        .irq_n(irq_n)
    );

    // ---------------- reference model ----------------
    logic [15:0] m_gctl, m_gisr, m_gmask, m_rdata;
    logic [15:0] m_cctl [NCH];
    logic [15:0] m_cisr [NCH];
    logic [15:0] m_cmask [NCH];

    function automatic logic [15:0] m_read(input logic [15:0] a);
        int h = int'(a[15:8]);
        if (h == 0 && a[7:0] == 8'h00) return m_gctl;
        if (h == 0 && a[7:0] == 8'h02) return m_gisr;
        if (h == 0 && a[7:0] == 8'h04) return m_gmask;
        if (h < NCH) begin
            if (a[7:0] == 8'h10) return m_cctl[h];
            if (a[7:0] == 8'h12) return ch_stat_i[h*16 +: 16];
            if (a[7:0] == 8'h14) return m_cisr[h];
            if (a[7:0] == 8'h16) return m_cmask[h];
        end
        return 16'h0000;
    endfunction

    always @(posedge clk) begin
        logic [15:0] lm;
        int h;
        lm = {{8{bus_be[1]}}, {8{bus_be[0]}}};
        h  = int'(bus_addr[15:8]);
        if (!rst_n) begin
            started = 1;
            m_gctl = 16'h0001; m_gisr = 0; m_gmask = 16'hFFFF; m_rdata = 0;
            for (int c = 0; c < NCH; c++) begin
                m_cctl[c] = 0; m_cisr[c] = 0; m_cmask[c] = 16'hFFFF;
            end
        end else begin
            if (bus_rd) begin
                m_rdata = m_read(bus_addr);
                if (h == 0 && bus_addr[7:0] == 8'h02) m_gisr &= ~lm;
                if (h < NCH && bus_addr[7:0] == 8'h14) m_cisr[h] &= ~lm;
            end
            if (bus_wr) begin
                if (h == 0 && bus_addr[7:0] == 8'h00) m_gctl = (m_gctl & ~lm) | (bus_wdata & lm);
                if (h == 0 && bus_addr[7:0] == 8'h04) m_gmask = (m_gmask & ~lm) | (bus_wdata & lm);
                if (h < NCH && bus_addr[7:0] == 8'h10) m_cctl[h] = (m_cctl[h] & ~lm) | (bus_wdata & lm);
                if (h < NCH && bus_addr[7:0] == 8'h16) m_cmask[h] = (m_cmask[h] & ~lm) | (bus_wdata & lm);
            end
            m_gisr |= glb_evt_i;
            for (int c = 0; c < NCH; c++) m_cisr[c] |= ch_evt_i[c*16 +: 16];
        end
    end

    task automatic check16(input logic [15:0] act, input logic [15:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (started) begin
            logic exp_irq;
            logic [NCH-1:0] exp_t1;
            exp_irq = 1'b1;
            if ((m_gisr & ~m_gmask) != 0) exp_irq = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                if ((m_cisr[c] & ~m_cmask[c]) != 0) exp_irq = 1'b0;
                exp_t1[c] = m_gctl[0] ? m_cctl[c][0] : m_gctl[1];
                check16(ch_cfg_o[c*16 +: 16], m_cctl[c], "R1 cfg");
            end
            check16({15'd0, irq_n}, {15'd0, exp_irq}, "R6 irq_n");
            check16({8'd0, ch_t1_o}, {8'd0, exp_t1}, "R10 rate");
            check16(bus_rdata, m_rdata, "R12 rdata");
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<=50000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr16(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic expect_rd(input logic [15:0] a, input logic [1:0] be,
                             input logic [15:0] exp, input string req);
        @(negedge clk); bus_addr = a; bus_be = be; bus_rd = 1;
        @(negedge clk); bus_rd = 0;
        check16(bus_rdata, exp, req);
    endtask

    task automatic ch_pulse(input int c, input logic [15:0] e);
        @(negedge clk); ch_evt_i[c*16 +: 16] = e;
        @(negedge clk); ch_evt_i = '0;
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string req);
        check16({15'd0, act}, {15'd0, exp}, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R11 / R5: reset values
        expect_rd(16'h0000, 2'b11, 16'h0001, "R11 gctl");
        expect_rd(16'h0510, 2'b11, 16'h0000, "R11 cctl");
        expect_rd(16'h0004, 2'b11, 16'hFFFF, "R5 gmask");
        expect_rd(16'h0316, 2'b11, 16'hFFFF, "R5 cmask");
        chk_bit(irq_n, 1'b1, "R11 irq_n");

        // R1: word and byte-lane writes
        wr16(16'h0210, 16'hA5C3, 2'b11);
        expect_rd(16'h0210, 2'b11, 16'hA5C3, "R1 word");
        wr16(16'h0210, 16'h1234, 2'b10);
        expect_rd(16'h0210, 2'b11, 16'h12C3, "R1 upper lane");
        wr16(16'h0210, 16'hFF77, 2'b01);
        expect_rd(16'h0210, 2'b11, 16'h1277, "R1 lower lane");

        // R7: channel independence
        wr16(16'h0010, 16'h1111, 2'b11);
        wr16(16'h0710, 16'h7777, 2'b11);
        expect_rd(16'h0110, 2'b11, 16'h0000, "R7 ch1 untouched");
        expect_rd(16'h0010, 2'b11, 16'h1111, "R7 ch0");
        expect_rd(16'h0710, 2'b11, 16'h7777, "R7 ch7");
        expect_rd(16'h0210, 2'b11, 16'h1277, "R7 ch2 kept");
        // R12: read data holds without new reads
        repeat (3) @(negedge clk);
        check16(bus_rdata, 16'h1277, "R12 hold");

        // R10: rate selection
        @(negedge clk);
        check16({8'd0, ch_t1_o}, 16'h0085, "R10 flexible");
        wr16(16'h0000, 16'h0002, 2'b11);
        check16({8'd0, ch_t1_o}, 16'h00FF, "R10 fixed T1");
        wr16(16'h0000, 16'h0000, 2'b11);
        check16({8'd0, ch_t1_o}, 16'h0000, "R10 fixed E1");
        wr16(16'h0000, 16'h0001, 2'b11);
        check16({8'd0, ch_t1_o}, 16'h0085, "R10 back to flexible");

        // R2: live status
        @(negedge clk); ch_stat_i[4*16 +: 16] = 16'hBEEF;
        expect_rd(16'h0412, 2'b11, 16'hBEEF, "R2 status");
        @(negedge clk); ch_stat_i[4*16 +: 16] = 16'h0123;
        expect_rd(16'h0412, 2'b11, 16'h0123, "R2 status follows");

        // R6 / R3: masked then unmasked event, read-to-clear
        ch_pulse(6, 16'h0008);
        chk_bit(irq_n, 1'b1, "R6 masked");
        wr16(16'h0616, 16'hFFF7, 2'b11);
        chk_bit(irq_n, 1'b0, "R6 unmasked");
        expect_rd(16'h0614, 2'b11, 16'h0008, "R3 read value");
        chk_bit(irq_n, 1'b1, "R3 cleared by read");
        expect_rd(16'h0614, 2'b11, 16'h0000, "R3 empty");

        // R3: byte-lane clear
        ch_pulse(6, 16'h0101);
        expect_rd(16'h0614, 2'b01, 16'h0101, "R3 byte read");
        expect_rd(16'h0614, 2'b11, 16'h0100, "R3 upper lane kept");

        // R4: event in the clearing cycle wins
        ch_pulse(6, 16'h0008);
        @(negedge clk); bus_addr = 16'h0614; bus_be = 2'b11; bus_rd = 1;
        ch_evt_i[6*16 +: 16] = 16'h0008;
        @(negedge clk); bus_rd = 0; ch_evt_i = '0;
        check16(bus_rdata, 16'h0008, "R4 read value");
        chk_bit(irq_n, 1'b0, "R4 bit kept");
        expect_rd(16'h0614, 2'b11, 16'h0008, "R4 bit still set");
        chk_bit(irq_n, 1'b1, "R4 cleared later");

        // R9: undecoded and read-only accesses
        ch_pulse(1, 16'h0001);
        expect_rd(16'h0115, 2'b11, 16'h0000, "R9 odd offset");
        expect_rd(16'h0914, 2'b11, 16'h0000, "R9 channel out of range");
        expect_rd(16'h0006, 2'b11, 16'h0000, "R9 gap offset");
        wr16(16'h0114, 16'h0000, 2'b11);
        wr16(16'h0614, 16'hFFFF, 2'b11);
        expect_rd(16'h0614, 2'b11, 16'h0000, "R9 flag write ignored");
        expect_rd(16'h0114, 2'b11, 16'h0001, "R9 flag survived");

        // R8: global bank
        @(negedge clk); glb_evt_i = 16'h0020;
        @(negedge clk); glb_evt_i = '0;
        chk_bit(irq_n, 1'b1, "R8 global masked");
        wr16(16'h0004, 16'hFFDF, 2'b11);
        chk_bit(irq_n, 1'b0, "R8 global unmasked");
        expect_rd(16'h0002, 2'b11, 16'h0020, "R8 global flags");
        chk_bit(irq_n, 1'b1, "R8 global cleared");
        expect_rd(16'h0010, 2'b11, 16'h1111, "R8 no alias with ch0");

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule